// File: doc/BRIEF.md
# Manager-Channel CSR Unit

This block serves the control/status register accesses of one processor core. Each access names a 12-bit register number, says whether it is a read or a write, and is answered in the same cycle by a read value, an error flag and a stall flag. Two of the registers are mapped onto message channels that connect the core to a host manager. A read of the inbound register takes the head entry from an external valid/ready source. A write of the outbound register offers the write data to an external valid/ready sink. The core must hold the access steady while the stall flag is high. It moves on in the cycle where the stall flag drops, which is also the only cycle in which the handshake fires.

The unit also returns a fixed core identifier and a fixed core count, both set by module parameters. It keeps a one-bit statistics switch that gates a free-running cycle counter and a counter of retired instructions. The core signals retirement with one pulse input. The unit runs in machine mode only and makes no privilege checks. The read-modify-write forms of CSR access are not part of the unit.

Top module: `csr_mgr_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low) and in the first cycle after it, `stat_en`, `cyc_count` and `ret_count` are zero.
- R2: A read (`csr_wr`=0) of number 0xFC0 while `inb_valid` is high drives `inb_ready` high and `csr_stall` low, and returns `inb_data` on `csr_rdata` in that same cycle. One entry is taken per access.
- R3: A read of 0xFC0 while `inb_valid` is low raises `csr_stall`. No entry is taken until `inb_valid` rises while the read is still held.
- R4: A write (`csr_wr`=1) of 0x7C0 drives `outb_valid` high with `outb_data` equal to `csr_wdata`. `csr_stall` is high exactly while `outb_ready` is low. Each access delivers its data once, in order.
- R5: A read of 0xF14 returns the parameter CORE_ID. A read of 0xFC1 returns the parameter NUM_CORES.
- R6: A write of 0x7C1 loads `csr_wdata` bit 0 into `stat_en` at the next clock edge. A read of 0x7C1 returns `stat_en` in bit 0 and zeros elsewhere.
- R7: While `stat_en` is high, `cyc_count` increases by one at every edge, and `ret_count` increases by one at every edge where `retire` is high. While `stat_en` is low, both counters hold. The value of `stat_en` before an edge decides that edge.
- R8: A read of any number other than 0xFC0, 0xF14, 0xFC1 or 0x7C1, and a write of any number other than 0x7C0 or 0x7C1, raises `csr_err` in the same cycle. Such an access returns zero, does not stall, fires no handshake and changes no state.
- R9: Without a request (`csr_req`=0), `inb_ready`, `outb_valid`, `csr_stall`, `csr_err` and `csr_rdata` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_req | input | 1 | An access is presented this cycle |
| csr_wr | input | 1 | 1 = write, 0 = read |
| csr_num | input | 12 | Register number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data |
| csr_stall | output | 1 | Access cannot complete this cycle |
| csr_err | output | 1 | Unsupported number or direction |
| inb_valid | input | 1 | Inbound channel holds an entry |
| inb_data | input | XLEN | Inbound head entry |
| inb_ready | output | 1 | Inbound dequeue request |
| outb_valid | output | 1 | Outbound enqueue request |
| outb_data | output | XLEN | Outbound data |
| outb_ready | input | 1 | Outbound channel can accept |
| retire | input | 1 | One instruction retired this cycle |
| stat_en | output | 1 | Statistics switch |
| cyc_count | output | CNT_W | Enabled cycle count |
| ret_count | output | CNT_W | Enabled retired-instruction count |

## Verification
Two functions can act in the same cycle. The first is a write of the statistics switch. The second is a counter update driven by a retirement pulse or by the cycle count. The bench raises `retire` during the cycle in which it writes the switch, in both directions. It expects that edge to count under the old switch value, and it expects the new value to apply from the following edge. A stalled channel access held over several cycles while the counters run is also compared on every clock against a behavioural model. That model checks that the stall never disturbs counting and that exactly one transfer occurs.

// File: rtl/csr_mgr_pkg.sv
package csr_mgr_pkg;

  localparam int unsigned NUM_W = 12;

  localparam logic [NUM_W-1:0] NUM_TO_HOST   = 12'h7C0;
  localparam logic [NUM_W-1:0] NUM_STAT_EN   = 12'h7C1;
  localparam logic [NUM_W-1:0] NUM_FROM_HOST = 12'hFC0;
  localparam logic [NUM_W-1:0] NUM_CORE_CNT  = 12'hFC1;
  localparam logic [NUM_W-1:0] NUM_CORE_ID   = 12'hF14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TO_HOST,
    SEL_FROM_HOST,
    SEL_CORE_ID,
    SEL_CORE_CNT,
    SEL_STAT_EN
  } csr_sel_e;

  // Map a register number onto an internal selector.
  function automatic csr_sel_e csr_lookup(logic [NUM_W-1:0] n);
    csr_sel_e s;
    unique case (n)
      NUM_TO_HOST:   s = SEL_TO_HOST;
      NUM_FROM_HOST: s = SEL_FROM_HOST;
      NUM_CORE_ID:   s = SEL_CORE_ID;
      NUM_CORE_CNT:  s = SEL_CORE_CNT;
      NUM_STAT_EN:   s = SEL_STAT_EN;
      default:       s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Whether the selected register supports the requested direction.
  function automatic logic csr_dir_ok(csr_sel_e s, logic wr);
    logic ok;
    case (s)
      SEL_TO_HOST:   ok = wr;
      SEL_STAT_EN:   ok = 1'b1;
      SEL_FROM_HOST,
      SEL_CORE_ID,
      SEL_CORE_CNT:  ok = !wr;
      default:       ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/csr_mgr_decode.sv
module csr_mgr_decode
  import csr_mgr_pkg::*;
(
  input  logic             req,
  input  logic             wr,
  input  logic [NUM_W-1:0] num,
  output csr_sel_e         sel,
  output logic             legal_rd,
  output logic             legal_wr,
  output logic             err
);

  logic dir_ok;

  always_comb begin
    sel      = csr_lookup(num);
    dir_ok   = csr_dir_ok(sel, wr);
    legal_rd = req && !wr && dir_ok;
    legal_wr = req &&  wr && dir_ok;
    err      = req && !dir_ok;
  end

endmodule

// File: rtl/csr_mgr_chan.sv
module csr_mgr_chan #(
  parameter int unsigned XLEN = 32
) (
  input  logic            deq_req,
  input  logic            enq_req,
  input  logic [XLEN-1:0] enq_data,
  input  logic            inb_valid,
  output logic            inb_ready,
  output logic            outb_valid,
  output logic [XLEN-1:0] outb_data,
  input  logic            outb_ready,
  output logic            stall,
  output logic            deq_fire,
  output logic            enq_fire
);

  always_comb begin
    inb_ready  = deq_req;
    outb_valid = enq_req;
    outb_data  = enq_req ? enq_data : '0;
    deq_fire   = deq_req && inb_valid;
    enq_fire   = enq_req && outb_ready;
    stall      = (deq_req && !inb_valid) || (enq_req && !outb_ready);
  end

endmodule

// File: rtl/csr_mgr_stats.sv
module csr_mgr_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             retire,
  output logic             stat_en,
  output logic [CNT_W-1:0] cyc_count,
  output logic [CNT_W-1:0] ret_count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] v, logic go);
    return go ? v + ONE : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_en   <= 1'b0;
      cyc_count <= '0;
      ret_count <= '0;
    end else begin
      if (en_wr) stat_en <= en_val;
      cyc_count <= bump(cyc_count, stat_en);
      ret_count <= bump(ret_count, stat_en && retire);
    end
  end

endmodule

// File: rtl/csr_mgr_unit.sv
module csr_mgr_unit
  import csr_mgr_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned CORE_ID   = 0,
  parameter int unsigned NUM_CORES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_req,
  input  logic             csr_wr,
  input  logic [11:0]      csr_num,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_stall,
  output logic             csr_err,
  input  logic             inb_valid,
  input  logic [XLEN-1:0]  inb_data,
  output logic             inb_ready,
  output logic             outb_valid,
  output logic [XLEN-1:0]  outb_data,
  input  logic             outb_ready,
  input  logic             retire,
  output logic             stat_en,
  output logic [CNT_W-1:0] cyc_count,
  output logic [CNT_W-1:0] ret_count
);

  localparam logic [XLEN-1:0] ID_WORD  = XLEN'(CORE_ID);
  localparam logic [XLEN-1:0] CNT_WORD = XLEN'(NUM_CORES);

  csr_sel_e sel;
  logic     legal_rd, legal_wr;
  logic     deq_req, enq_req;
  logic     deq_fire, enq_fire;
  logic     en_wr;

  csr_mgr_decode u_dec (
    .req      (csr_req),
    .wr       (csr_wr),
    .num      (csr_num),
    .sel      (sel),
    .legal_rd (legal_rd),
    .legal_wr (legal_wr),
    .err      (csr_err)
  );

  assign deq_req = legal_rd && (sel == SEL_FROM_HOST);
  assign enq_req = legal_wr && (sel == SEL_TO_HOST);
  assign en_wr   = legal_wr && (sel == SEL_STAT_EN);

  csr_mgr_chan #(.XLEN(XLEN)) u_chan (
    .deq_req    (deq_req),
    .enq_req    (enq_req),
    .enq_data   (csr_wdata),
    .inb_valid  (inb_valid),
    .inb_ready  (inb_ready),
    .outb_valid (outb_valid),
    .outb_data  (outb_data),
    .outb_ready (outb_ready),
    .stall      (csr_stall),
    .deq_fire   (deq_fire),
    .enq_fire   (enq_fire)
  );

  csr_mgr_stats #(.CNT_W(CNT_W)) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_val    (csr_wdata[0]),
    .retire    (retire),
    .stat_en   (stat_en),
    .cyc_count (cyc_count),
    .ret_count (ret_count)
  );

  // Read-data selection: zero unless a supported read is presented.
  always_comb begin
    csr_rdata = '0;
    if (legal_rd) begin
      case (sel)
        SEL_FROM_HOST: csr_rdata = inb_data;
        SEL_CORE_ID:   csr_rdata = ID_WORD;
        SEL_CORE_CNT:  csr_rdata = CNT_WORD;
        SEL_STAT_EN:   csr_rdata = {{(XLEN-1){1'b0}}, stat_en};
        default:       csr_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/csr_mgr_unit_chk.sv
module csr_mgr_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_req,
  input logic             csr_wr,
  input logic [11:0]      csr_num,
  input logic [XLEN-1:0]  csr_wdata,
  input logic [XLEN-1:0]  csr_rdata,
  input logic             csr_stall,
  input logic             csr_err,
  input logic             inb_valid,
  input logic [XLEN-1:0]  inb_data,
  input logic             inb_ready,
  input logic             outb_valid,
  input logic [XLEN-1:0]  outb_data,
  input logic             outb_ready,
  input logic             retire,
  input logic             stat_en,
  input logic [CNT_W-1:0] cyc_count,
  input logic [CNT_W-1:0] ret_count,
  input logic             deq_fire,
  input logic             enq_fire,
  input logic             en_wr
);

  logic rd_in, wr_out, wr_en;
  assign rd_in  = csr_req && !csr_wr && (csr_num == 12'hFC0);
  assign wr_out = csr_req &&  csr_wr && (csr_num == 12'h7C0);
  assign wr_en  = csr_req &&  csr_wr && (csr_num == 12'h7C1);

  a_r2_deq_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    deq_fire |-> (inb_ready && inb_valid && !csr_stall && csr_rdata == inb_data));

  a_r3_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in && !inb_valid) |-> (csr_stall && !deq_fire));

  a_r4_enq_offer: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |-> (outb_valid && outb_data == csr_wdata && csr_stall == !outb_ready
                && enq_fire == outb_ready));

  a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && en_wr) |=> (stat_en == $past(csr_wdata[0])));

  a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en |=> (cyc_count == CNT_W'($past(cyc_count) + 1'b1)));

  a_r7_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_en |=> $stable(cyc_count));

  a_r7_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_en && retire) |=> (ret_count == CNT_W'($past(ret_count) + 1'b1)));

  a_r7_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_en && retire) |=> $stable(ret_count));

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |-> (!csr_stall && !inb_ready && !outb_valid && csr_rdata == '0 && !en_wr));

  a_r8_err_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |=> $stable(stat_en));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |-> (!inb_ready && !outb_valid && !csr_stall && !csr_err && csr_rdata == '0));

endmodule

bind csr_mgr_unit csr_mgr_unit_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_req    (csr_req),
  .csr_wr     (csr_wr),
  .csr_num    (csr_num),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata),
  .csr_stall  (csr_stall),
  .csr_err    (csr_err),
  .inb_valid  (inb_valid),
  .inb_data   (inb_data),
  .inb_ready  (inb_ready),
  .outb_valid (outb_valid),
  .outb_data  (outb_data),
  .outb_ready (outb_ready),
  .retire     (retire),
  .stat_en    (stat_en),
  .cyc_count  (cyc_count),
  .ret_count  (ret_count),
  .deq_fire   (deq_fire),
  .enq_fire   (enq_fire),
  .en_wr      (en_wr)
);

// File: tb/csr_mgr_unit_test.sv
module csr_mgr_unit_test;

  localparam int XL = 32;
  localparam int CW = 32;
  localparam int MY_ID = 5;
  localparam int MY_CORES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [11:0] num = '0;
  logic [XL-1:0] wdata = '0, in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0, retire = 1'b0;
  logic [XL-1:0] rdata, out_data;
  logic stall, err, in_ready, out_valid, en;
  logic [CW-1:0] cyc, ret;

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_en = 0;
  longint m_cyc = 0, m_ret = 0;
  int deq_seen = 0, deq_want = 0;
  logic [XL-1:0] enq_want[$];
  logic [XL-1:0] enq_got[$];

  always #10ns clk = ~clk;

  csr_mgr_unit #(.XLEN(XL), .CNT_W(CW), .CORE_ID(MY_ID), .NUM_CORES(MY_CORES)) uut (
    .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_wr(wr), .csr_num(num),
    .csr_wdata(wdata), .csr_rdata(rdata), .csr_stall(stall), .csr_err(err),
    .inb_valid(in_valid), .inb_data(in_data), .inb_ready(in_ready),
    .outb_valid(out_valid), .outb_data(out_data), .outb_ready(out_ready),
    .retire(retire), .stat_en(en), .cyc_count(cyc), .ret_count(ret)
  );

  function automatic bit known_ok(bit w, logic [11:0] n);
    if (w) return (n == 12'h7C0) || (n == 12'h7C1);
    return (n == 12'hFC0) || (n == 12'hF14) || (n == 12'hFC1) || (n == 12'h7C1);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // model update on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_cyc <= 0; m_ret <= 0;
    end else begin
      if (req && wr && num == 12'h7C1) m_en <= wdata[0];
      if (m_en) begin
        m_cyc <= (m_cyc + 1) & 64'hFFFF_FFFF;
        if (retire) m_ret <= (m_ret + 1) & 64'hFFFF_FFFF;
      end
      if (in_ready && in_valid) deq_seen <= deq_seen + 1;
      if (out_valid && out_ready) enq_got.push_back(out_data);
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    #2ns;
    if (!finished) begin
      bit okc, e_err, e_stall, e_inr, e_outv;
      logic [XL-1:0] e_rd;
      okc     = known_ok(wr, num);
      e_err   = req && !okc;
      e_inr   = req && !wr && num == 12'hFC0;
      e_outv  = req && wr && num == 12'h7C0;
      e_stall = (e_inr && !in_valid) || (e_outv && !out_ready);
      e_rd    = '0;
      if (req && !wr && okc) begin
        case (num)
          12'hFC0: e_rd = in_data;
          12'hF14: e_rd = MY_ID;
          12'hFC1: e_rd = MY_CORES;
          default: e_rd = {31'b0, m_en};
        endcase
      end
      chk(en == m_en, "R6/R1 stat_en", en, m_en);
      chk(cyc == m_cyc[CW-1:0], "R7/R1 cyc_count", cyc, m_cyc);
      chk(ret == m_ret[CW-1:0], "R7/R1 ret_count", ret, m_ret);
      chk(err == e_err, "R8 csr_err", err, e_err);
      chk(stall == e_stall, "R3/R4 csr_stall", stall, e_stall);
      chk(in_ready == e_inr, "R2/R9 inb_ready", in_ready, e_inr);
      chk(out_valid == e_outv, "R4/R9 outb_valid", out_valid, e_outv);
      if (e_outv) chk(out_data == wdata, "R4 outb_data", out_data, wdata);
      chk(rdata == e_rd, "R2/R5/R6 csr_rdata", rdata, e_rd);
    end
  end

  // one access; the channel side stays unready for dly cycles
  task automatic op(bit w, logic [11:0] n, logic [XL-1:0] d, int dly);
    @(negedge clk);
    req = 1; wr = w; num = n; wdata = d; in_data = d;
    in_valid = (dly == 0); out_ready = (dly == 0);
    if (w && n == 12'h7C0) enq_want.push_back(d);
    if (!w && n == 12'hFC0) deq_want++;
    for (int i = 0; i < dly; i++) @(negedge clk);
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    req = 0; wr = 0; num = '0; wdata = '0; in_data = '0;
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything at zero
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R5: fixed identity registers
    op(0, 12'hF14, 32'h0, 0);
    op(0, 12'hFC1, 32'h0, 0);
    // R6: enable counting, then read it back
    op(1, 12'h7C1, 32'hFFFF_FFF1, 0);
    op(0, 12'h7C1, 32'h0, 0);
    // R7: retire pattern while enabled
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); retire = (i % 3 != 0);
    end
    // R7: retire coinciding with switch-off, then with switch-on
    @(negedge clk); retire = 1;
    op(1, 12'h7C1, 32'h0, 0);
    repeat (3) @(negedge clk);
    op(1, 12'h7C1, 32'h1, 0);
    retire = 0;
    // R2: inbound ready at once; R3: inbound late
    op(0, 12'hFC0, 32'hA5A5_0001, 0);
    op(0, 12'hFC0, 32'h5A5A_0002, 3);
    // R4: outbound ready at once, then late, with retire running
    retire = 1;
    op(1, 12'h7C0, 32'h1234_5678, 0);
    op(1, 12'h7C0, 32'h8765_4321, 4);
    retire = 0;
    // R8: unsupported numbers and directions
    op(0, 12'h7C0, 32'h0, 0);
    op(1, 12'hF14, 32'h1, 0);
    op(1, 12'hFC0, 32'h1, 0);
    op(0, 12'h123, 32'h0, 0);
    op(1, 12'h7C2, 32'h0, 0);
    // R9: idle cycles
    repeat (3) @(negedge clk);
    // R2/R3: exactly one entry taken per inbound read
    chk(deq_seen == deq_want, "R2/R3 dequeue count", deq_seen, deq_want);
    // R4: outbound data once each, in order
    chk(enq_got.size() == enq_want.size(), "R4 enqueue count", enq_got.size(), enq_want.size());
    for (int i = 0; i < enq_want.size() && i < enq_got.size(); i++)
      chk(enq_got[i] == enq_want[i], "R4 enqueue order", enq_got[i], enq_want[i]);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule